// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer with Snapshot Readout

The block holds four independent 32-bit timers behind a single-cycle register port. Each timer counts downward from a programmable start value. It runs only while its own enable and a shared global enable are both set. When the count reaches zero, the next enabled cycle reloads the start value, adds one to a per-timer wrap counter and sets a sticky status flag. That flag, gated by a mask bit, drives the timer's interrupt line. The four lines are also ORed into one block interrupt.

Software reads the count coherently in two steps. A read of a timer's wrap-count register returns the wrap count and, in the same cycle, freezes the live count into a snapshot register. A later read of the count register returns that snapshot and never the live value. A free-running time base is the bitwise inverse of the snapshot when the start value is all ones.

The register port is plain control: a read strobe returns data on the next cycle with `rd_valid`, and a write takes effect at the clock edge that samples it. There is no back-pressure, and a strobe is always accepted.

Top module: `mtimer_latch`

## Requirements
- R1: After reset, every enable, mask, status, count, snapshot and wrap-count register reads 0, the start-value registers read 0xFFFFFFFF, and `irq_o` and `chan_irq` are 0.
- R2: Byte address 0x00 holds the global enable in bit 0, and 0x10 is a read-only revision word equal to the `REV_ID` parameter. Timer k uses the window at 0x20+0x20*k with these offsets: 0x00 local enable (bit 0), 0x04 start value, 0x08 count snapshot, 0x0C wrap count, 0x10 status (bit 0), 0x14 clear (write-only, reads 0), 0x18 mask (bit 0). Any other address reads 0.
- R3: A timer whose local enable is 1 holds its count in any cycle where the global enable is 0.
- R4: While a timer's local enable is 0, its count is loaded from the start value every cycle. Once the enable is 1 and the global enable is 1, the count falls by one per cycle.
- R5: An enabled tick with count 0 reloads the start value, adds 1 to the wrap count and sets status bit 0.
- R6: A read of the wrap-count register captures the live count. A read of the count register returns the most recent capture and not the live count.
- R7: Writing a value with bit 0 set to the clear register clears status. If a wrap sets status in the same cycle, the status stays 1.
- R8: `chan_irq[k]` is status AND mask of timer k, and `irq_o` is the OR of all `chan_irq` bits.
- R9: Read data appears on `bus_rdata` with `rd_valid` high in the cycle after the read strobe.
- R10: Writes to the revision, count, wrap-count and status registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| rd_valid | output | 1 | Marks `bus_rdata` as valid |
| chan_irq | output | 4 | Per-timer interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first is a wrap that sets status while software writes the clear register. A start value of 0 makes a timer wrap on every enabled cycle, so any clear write collides with a wrap; the bench then expects status to read back 1. The second is a wrap-count read that lands on the wrapping cycle. Random traffic with small start values makes this happen often. The bench model expects the pre-edge wrap count from that read and a captured count of 0.

// File: rtl/mtl_pkg.sv
`timescale 1ns/1ps
package mtl_pkg;
  localparam int GLOB_OFS   = 'h00;
  localparam int REV_OFS    = 'h10;
  localparam int WIN_BASE   = 'h20;
  localparam int WIN_STRIDE = 'h20;

  typedef enum logic [2:0] {
    RG_CFG, RG_RELOAD, RG_CUR, RG_OVF, RG_STAT, RG_CLR, RG_MASK, RG_NONE
  } chan_reg_e;

  function automatic chan_reg_e reg_of(input int off);
    case (off)
      'h00:    return RG_CFG;
      'h04:    return RG_RELOAD;
      'h08:    return RG_CUR;
      'h0C:    return RG_OVF;
      'h10:    return RG_STAT;
      'h14:    return RG_CLR;
      'h18:    return RG_MASK;
      default: return RG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mtl_decode.sv
`timescale 1ns/1ps
module mtl_decode #(
  parameter int ADDR_W = 8,
  parameter int N_CHAN = 4,
  parameter int CW     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_glob,
  output logic              hit_rev,
  output logic              hit_chan,
  output logic [CW-1:0]     chan_sel,
  output mtl_pkg::chan_reg_e reg_sel
);
  import mtl_pkg::*;

  always_comb begin
    int a;
    a        = int'(addr);
    hit_glob = (a == GLOB_OFS);
    hit_rev  = (a == REV_OFS);
    hit_chan = 1'b0;
    chan_sel = '0;
    reg_sel  = RG_NONE;
    for (int i = 0; i < N_CHAN; i++) begin
      int off;
      off = a - (WIN_BASE + WIN_STRIDE * i);
      if (off >= 0 && off < WIN_STRIDE && reg_of(off) != RG_NONE) begin
        hit_chan = 1'b1;
        chan_sel = CW'(i);
        reg_sel  = reg_of(off);
      end
    end
  end
endmodule

// File: rtl/mtl_channel.sv
`timescale 1ns/1ps
module mtl_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glob_en,
  input  logic          wr_cfg,
  input  logic          wr_reload,
  input  logic          wr_clr,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  input  logic          take_snap,
  output logic          cfg_q,
  output logic          mask_q,
  output logic          stat_q,
  output logic [DW-1:0] reload_q,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] ovf_q,
  output logic [DW-1:0] snap_q,
  output logic          irq
);
  logic tick, wrap;

  assign tick = cfg_q & glob_en;
  assign wrap = tick && (cnt_q == '0);
  assign irq  = stat_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= 1'b0;
      mask_q   <= 1'b0;
      stat_q   <= 1'b0;
      reload_q <= '1;
      cnt_q    <= '0;
      ovf_q    <= '0;
      snap_q   <= '0;
    end else begin
      if (wr_cfg)    cfg_q    <= wdata[0];
      if (wr_mask)   mask_q   <= wdata[0];
      if (wr_reload) reload_q <= wdata;
      if (take_snap) snap_q   <= cnt_q;

      if (!cfg_q)       cnt_q <= reload_q;
      else if (wrap)    cnt_q <= reload_q;
      else if (tick)    cnt_q <= cnt_q - DW'(1);

      if (wrap) ovf_q <= ovf_q + DW'(1);

      if (wrap)                     stat_q <= 1'b1;
      else if (wr_clr && wdata[0])  stat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mtimer_latch.sv
`timescale 1ns/1ps
module mtimer_latch #(
  parameter int          N_CHAN = 4,
  parameter int          DW     = 32,
  parameter int          ADDR_W = 8,
  parameter logic [31:0] REV_ID = 32'h0001_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              rd_valid,
  output logic [N_CHAN-1:0] chan_irq,
  output logic              irq_o
);
  import mtl_pkg::*;
  localparam int CW = (N_CHAN > 1) ? $clog2(N_CHAN) : 1;

  logic                         glob_en;
  logic                         hit_glob, hit_rev, hit_chan;
  logic [CW-1:0]                chan_sel;
  chan_reg_e                    reg_sel;
  logic [N_CHAN-1:0]            cfg_vec, mask_vec, stat_vec;
  logic [N_CHAN-1:0][DW-1:0]    reload_arr, cnt_arr, ovf_arr, snap_arr;
  logic [DW-1:0]                rd_mux;

  mtl_decode #(.ADDR_W(ADDR_W), .N_CHAN(N_CHAN), .CW(CW)) u_dec (
    .addr(bus_addr), .hit_glob(hit_glob), .hit_rev(hit_rev),
    .hit_chan(hit_chan), .chan_sel(chan_sel), .reg_sel(reg_sel)
  );

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    logic sel_w, sel_r;
    assign sel_w = bus_wr && hit_chan && (chan_sel == CW'(g));
    assign sel_r = bus_rd && hit_chan && (chan_sel == CW'(g));
    mtl_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en),
      .wr_cfg(sel_w && reg_sel == RG_CFG),
      .wr_reload(sel_w && reg_sel == RG_RELOAD),
      .wr_clr(sel_w && reg_sel == RG_CLR),
      .wr_mask(sel_w && reg_sel == RG_MASK),
      .wdata(bus_wdata),
      .take_snap(sel_r && reg_sel == RG_OVF),
      .cfg_q(cfg_vec[g]), .mask_q(mask_vec[g]), .stat_q(stat_vec[g]),
      .reload_q(reload_arr[g]), .cnt_q(cnt_arr[g]), .ovf_q(ovf_arr[g]),
      .snap_q(snap_arr[g]), .irq(chan_irq[g])
    );
  end

  assign irq_o = |chan_irq;

  always_comb begin
    rd_mux = '0;
    if (hit_glob)     rd_mux = DW'(glob_en);
    else if (hit_rev) rd_mux = DW'(REV_ID);
    else if (hit_chan) begin
      case (reg_sel)
        RG_CFG:    rd_mux = DW'(cfg_vec[chan_sel]);
        RG_RELOAD: rd_mux = reload_arr[chan_sel];
        RG_CUR:    rd_mux = snap_arr[chan_sel];
        RG_OVF:    rd_mux = ovf_arr[chan_sel];
        RG_STAT:   rd_mux = DW'(stat_vec[chan_sel]);
        RG_MASK:   rd_mux = DW'(mask_vec[chan_sel]);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en   <= 1'b0;
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      if (bus_wr && hit_glob) glob_en <= bus_wdata[0];
      rd_valid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mtl_checker.sv
`timescale 1ns/1ps
module mtl_checker #(
  parameter int          N_CHAN = 4,
  parameter int          DW     = 32,
  parameter int          ADDR_W = 8,
  parameter logic [31:0] REV_ID = 32'h0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_rd,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DW-1:0]             bus_rdata,
  input logic                      rd_valid,
  input logic                      irq_o,
  input logic                      glob_en,
  input logic [N_CHAN-1:0]         cfg_vec,
  input logic [N_CHAN-1:0]         stat_vec,
  input logic [N_CHAN-1:0][DW-1:0] reload_arr,
  input logic [N_CHAN-1:0][DW-1:0] cnt_arr,
  input logic [N_CHAN-1:0][DW-1:0] ovf_arr,
  input logic [N_CHAN-1:0][DW-1:0] snap_arr
);
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) == 'h04) |=> (bus_rdata == '0));

  a_r2_rev_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) == 'h10) |=> (bus_rdata == DW'(REV_ID)));

  a_r9_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_vec != '0));

  for (genvar i = 0; i < N_CHAN; i++) begin : g_ck
    a_r3_hold_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_vec[i] && !glob_en) |=> (cnt_arr[i] == $past(cnt_arr[i])));

    a_r4_track_reload: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_vec[i] |=> (cnt_arr[i] == $past(reload_arr[i])));

    a_r5_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ovf_arr[i]) |-> (ovf_arr[i] == $past(ovf_arr[i]) + DW'(1)));

    a_r5_status_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_vec[i]) |-> ($past(cnt_arr[i]) == '0));

    a_r6_cur_from_snap: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && int'(bus_addr) == 'h28 + 'h20 * i) |=> (bus_rdata == $past(snap_arr[i])));
  end
endmodule

bind mtimer_latch mtl_checker #(
  .N_CHAN(N_CHAN), .DW(DW), .ADDR_W(ADDR_W), .REV_ID(REV_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .rd_valid(rd_valid), .irq_o(irq_o),
  .glob_en(glob_en), .cfg_vec(cfg_vec), .stat_vec(stat_vec),
  .reload_arr(reload_arr), .cnt_arr(cnt_arr), .ovf_arr(ovf_arr),
  .snap_arr(snap_arr)
);

// File: tb/mtimer_latch_bench.sv
`timescale 1ns/1ps
module mtimer_latch_bench;
  localparam int NC = 4;
  localparam logic [31:0] REV = 32'h0001_0003;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rd_valid;
  logic [NC-1:0] chan_irq;
  logic irq_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mtimer_latch #(.N_CHAN(NC), .REV_ID(REV)) u_mtimer_latch (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .chan_irq(chan_irq), .irq_o(irq_o)
  );

  // reference model built from the requirements
  logic        m_glob;
  logic [NC-1:0] m_cfg, m_mask, m_stat;
  logic [31:0] m_rel[NC], m_cnt[NC], m_ovf[NC], m_snap[NC];
  logic [31:0] m_rdata;

  function automatic int win(int ch, int off);
    return 'h20 + 'h20 * ch + off;
  endfunction

  function automatic logic [31:0] expect_read(int a);
    for (int c = 0; c < NC; c++) begin
      if (a == win(c, 'h00)) return {31'b0, m_cfg[c]};
      if (a == win(c, 'h04)) return m_rel[c];
      if (a == win(c, 'h08)) return m_snap[c];
      if (a == win(c, 'h0C)) return m_ovf[c];
      if (a == win(c, 'h10)) return {31'b0, m_stat[c]};
      if (a == win(c, 'h18)) return {31'b0, m_mask[c]};
    end
    if (a == 'h00) return {31'b0, m_glob};
    if (a == 'h10) return REV;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_glob <= 0; m_cfg <= '0; m_mask <= '0; m_stat <= '0; m_rdata <= '0;
      for (int c = 0; c < NC; c++) begin
        m_rel[c] <= '1; m_cnt[c] <= '0; m_ovf[c] <= '0; m_snap[c] <= '0;
      end
    end else begin
      if (bus_rd) m_rdata <= expect_read(int'(bus_addr));
      if (bus_wr && bus_addr == 8'h00) m_glob <= bus_wdata[0];
      for (int c = 0; c < NC; c++) begin
        bit run;
        run = m_cfg[c] && m_glob;
        if (bus_rd && int'(bus_addr) == win(c, 'h0C)) m_snap[c] <= m_cnt[c];
        if (bus_wr && int'(bus_addr) == win(c, 'h00)) m_cfg[c] <= bus_wdata[0];
        if (bus_wr && int'(bus_addr) == win(c, 'h04)) m_rel[c] <= bus_wdata;
        if (bus_wr && int'(bus_addr) == win(c, 'h18)) m_mask[c] <= bus_wdata[0];
        if (bus_wr && int'(bus_addr) == win(c, 'h14) && bus_wdata[0]) m_stat[c] <= 1'b0;
        if (!m_cfg[c]) m_cnt[c] <= m_rel[c];
        else if (run) begin
          if (m_cnt[c] == 0) begin
            m_cnt[c] <= m_rel[c];
            m_ovf[c] <= m_ovf[c] + 1;
            m_stat[c] <= 1'b1;
          end else m_cnt[c] <= m_cnt[c] - 1;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  // read checked against the model; returns the observed data
  task automatic rd(int a, string req, output logic [31:0] got);
    @(negedge clk);
    bus_rd = 1; bus_addr = 8'(a);
    @(negedge clk);
    bus_rd = 0;
    got = bus_rdata;
    check({req, " R9"}, {31'b0, rd_valid}, 32'd1);
    check(req, bus_rdata, m_rdata);
  endtask

  task automatic chk_irq(string req);
    check(req, {27'b0, irq_o, chan_irq}, {27'b0, |(m_stat & m_mask), m_stat & m_mask});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, snap1, snap2;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {27'b0, irq_o, chan_irq}, 32'h0);
    for (int c = 0; c < NC; c++) begin
      rd(win(c, 'h04), "R1 reload", v); check("R1 reload literal", v, 32'hFFFF_FFFF);
      rd(win(c, 'h00), "R1 cfg", v);    check("R1 cfg literal", v, 32'h0);
      rd(win(c, 'h0C), "R1 ovf", v);    check("R1 ovf literal", v, 32'h0);
      rd(win(c, 'h08), "R1 cur", v);
      rd(win(c, 'h10), "R1 stat", v);
      rd(win(c, 'h18), "R1 mask", v);
    end

    // R2 map, revision, unmapped; R10 revision write ignored
    rd('h10, "R2 rev", v); check("R2 rev literal", v, REV);
    wr('h10, 32'hDEAD_BEEF);
    rd('h10, "R10 rev write", v); check("R10 rev literal", v, REV);
    rd('h04, "R2 unmapped", v); check("R2 unmapped literal", v, 32'h0);
    rd(win(0, 'h1C), "R2 unmapped win", v);
    rd('hC0, "R2 unmapped high", v);
    rd(win(2, 'h14), "R2 clear reads zero", v); check("R2 clear literal", v, 32'h0);

    // R4 count down from start value after enable
    wr(win(0, 'h04), 32'd1000);
    wr('h00, 1);
    wr(win(0, 'h00), 1);
    idle(10);
    rd(win(0, 'h0C), "R4 ovf", v);
    rd(win(0, 'h08), "R4 cur", snap1);
    idle(5);
    rd(win(0, 'h08), "R6 cur repeat", snap2);
    check("R6 stale snapshot", snap2, snap1);

    // R3 hold with global off
    wr('h00, 0);
    rd(win(0, 'h0C), "R3 ovf", v);
    rd(win(0, 'h08), "R3 cur a", snap1);
    idle(8);
    rd(win(0, 'h0C), "R3 ovf 2", v);
    rd(win(0, 'h08), "R3 cur b", snap2);
    check("R3 held", snap2, snap1);
    wr('h00, 1);

    // R5, R8 wrap and interrupt
    wr(win(1, 'h04), 32'd3);
    wr(win(1, 'h18), 1);
    wr(win(1, 'h00), 1);
    idle(12);
    chk_irq("R8 raised");
    rd(win(1, 'h10), "R5 status", v); check("R5 status literal", v, 32'h1);
    rd(win(1, 'h0C), "R5 ovf count", v);
    // R10 writes to status/count/ovf ignored
    wr(win(1, 'h00), 0);
    wr(win(1, 'h10), 0);
    wr(win(1, 'h0C), 32'h55);
    wr(win(1, 'h08), 32'h66);
    rd(win(1, 'h10), "R10 status", v);
    rd(win(1, 'h0C), "R10 ovf", v);
    rd(win(1, 'h08), "R10 cur", v);
    // R7 clear, R8 mask
    wr(win(1, 'h14), 1);
    rd(win(1, 'h10), "R7 clear", v); check("R7 clear literal", v, 32'h0);
    chk_irq("R8 after clear");

    // R7 collision: start value 0 wraps every cycle
    wr(win(2, 'h04), 32'd0);
    wr(win(2, 'h00), 1);
    wr(win(2, 'h18), 0);
    idle(3);
    chk_irq("R8 masked");
    wr(win(2, 'h14), 1);
    rd(win(2, 'h10), "R7 set wins", v); check("R7 set wins literal", v, 32'h1);
    wr(win(2, 'h00), 0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int ch, op, offs[7];
      offs = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18};
      ch = int'($urandom % NC);
      op = int'($urandom % 12);
      case (op)
        0, 1: wr(win(ch, 'h04), $urandom % 24);
        2:    wr(win(ch, 'h00), $urandom % 4 != 0);
        3:    wr(win(ch, 'h18), $urandom % 2);
        4:    wr(win(ch, 'h14), $urandom);
        5:    wr('h00, $urandom % 5 != 0);
        6:    rd($urandom % 256, "R2 random addr", v);
        7:    wr(win(ch, offs[$urandom % 7]), $urandom);
        default: begin
          rd(win(ch, 'h0C), "R6 random ovf", v);
          rd(win(ch, offs[$urandom % 7]), "R5 random read", v);
        end
      endcase
      chk_irq("R8 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule